// File: doc/BRIEF.md
# IO interrupt redirection controller

This block turns a set of external interrupt pins into interrupt messages. Each pin owns a redirection entry. The entry holds the vector, the delivery mode, the polarity, the trigger mode, a mask and a destination. When an unmasked pin becomes active, the block sends one message that carries that entry's vector, destination and delivery mode. The message leaves through a valid/ready port.

Software reaches the entries indirectly. It first writes a register index into the select register. It then reads or writes the data window. A separate write-only end-of-interrupt register re-arms level-triggered pins. Every pin input passes through two synchronising flops. Its polarity is then applied, and only after that is the edge or level detected.

An edge that arrives while its pin is masked is discarded. A level pin fires once and stays silent until an end-of-interrupt names its vector. A destination written to the high word stays in a shadow register. It takes effect only when the low word of the same entry is written.

The arbiter is a two-state machine. In `ARB_IDLE` it waits for a request. The transition *grant* is taken when at least one pin requests. It picks the lowest requesting index, captures that entry's fields and moves to `ARB_SEND`. In `ARB_SEND` the message is presented. The transition *accept* is taken when `msg_ready` is high, and it returns to `ARB_IDLE`. Without `msg_ready` the machine stays in `ARB_SEND` and holds the message.

Top module: `ioredir_ctrl`

## Requirements
- R1: With the select register at 0x01, the window reads the version word. Bits 7:0 hold the version parameter, bits 23:16 hold the pin count minus one, and all other bits are 0.
- R2: After reset every entry's low word reads 0x0001_0000, which means masked with all other fields zero, and `msg_valid` is low.
- R3: Entry n has its low word at select value 0x10+2n and its high word at 0x11+2n. The low word layout is: vector in bits 7:0, delivery mode in bits 10:8, polarity in bit 13, trigger in bit 15 and mask in bit 16. Undefined bits read 0. The high word reads back its destination in bits 31:16 and 0 elsewhere.
- R4: An edge-triggered unmasked pin (trigger bit 0) yields exactly one message for each rising edge of its active level.
- R5: Polarity bit 1 means active low. A pin held at its inactive level raises no message.
- R6: An edge that occurs while the pin is masked is dropped. Unmasking the pin later produces no message for it.
- R7: A level-triggered pin (trigger bit 1) sends one message and then stays silent while it remains active. It sends again only after an end-of-interrupt write whose bits 7:0 equal its vector. That same write re-arms every pin that shares the vector. A write with a different vector has no effect.
- R8: A high-word write is held in a shadow register. The destination carried in messages changes only on the next low-word write to that entry.
- R9: When several pins request at once, the lowest pin index is sent first. At most one pin is granted per cycle.
- R10: While `msg_valid` is high and `msg_ready` is low, the message fields stay stable and valid stays high.
- R11: The 3-bit delivery mode field is carried unchanged into `msg_mode`. The encodings are fixed 000, lowest priority 001, PMI 010 and INIT 101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | NUM_PINS | Asynchronous interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | 0 = select, 1 = data window, 2 = end-of-interrupt |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the select register or the window |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vec | output | 8 | Message vector |
| msg_dest | output | 16 | Destination, id in the upper byte and eid in the lower byte |
| msg_mode | output | 3 | Delivery mode |

## Verification
The bench sweeps every pin of a four-pin configuration. Each pin gets its own vector, destination and delivery mode, so every message can be traced back to a single entry and a single mode encoding.

Active-low pins are driven both at rest and on a falling input. This separates a correct polarity inversion from a stale edge detector. Pulses given while a pin is masked are followed by an unmask, which shows whether a dropped edge stays dropped.

Two level pins share one vector and are raised together. A mismatching end-of-interrupt is then written, followed by a matching one. This shows both the priority order and the fact that a single write re-arms every sharing pin.

Simultaneous edges with `msg_ready` held low check the hold behaviour. A high-word write without a following low-word write checks that the destination shadow does not leak into messages.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;

    localparam logic [7:0] SEL_VERSION    = 8'h01;
    localparam logic [7:0] SEL_TABLE_BASE = 8'h10;

    localparam logic [1:0] BUS_SEL = 2'd0;
    localparam logic [1:0] BUS_WIN = 2'd1;
    localparam logic [1:0] BUS_EOI = 2'd2;

    localparam logic [2:0] DM_FIXED  = 3'b000;
    localparam logic [2:0] DM_LOWPRI = 3'b001;
    localparam logic [2:0] DM_PMI    = 3'b010;
    localparam logic [2:0] DM_INIT   = 3'b101;

    typedef struct packed {
        logic       mask;
        logic       trig;   // 1 = level
        logic       pol;    // 1 = active low
        logic [2:0] mode;
        logic [7:0] vec;
    } rte_lo_t;

    localparam rte_lo_t RTE_LO_RESET = '{mask: 1'b1, trig: 1'b0, pol: 1'b0,
                                         mode: 3'b000, vec: 8'h00};

    typedef enum logic {
        ARB_IDLE,
        ARB_SEND
    } arb_state_e;

    function automatic logic [31:0] pack_low(rte_lo_t e);
        return {15'b0, e.mask, e.trig, 1'b0, e.pol, 2'b00, e.mode, e.vec};
    endfunction

    function automatic rte_lo_t unpack_low(logic [31:0] w);
        rte_lo_t e;
        e.vec  = w[7:0];
        e.mode = w[10:8];
        e.pol  = w[13];
        e.trig = w[15];
        e.mask = w[16];
        return e;
    endfunction

endpackage

// File: rtl/ioredir_table.sv
module ioredir_table
    import ioredir_pkg::*;
#(
    parameter int         NUM_PINS = 4,
    parameter logic [7:0] VERSION  = 8'h21
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic [1:0]                    bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    output rte_lo_t [NUM_PINS-1:0]        rte_lo,
    output logic [NUM_PINS-1:0][15:0]     rte_dest,
    output logic                          eoi_valid,
    output logic [7:0]                    eoi_vec
);

    localparam int TBL_END = int'(SEL_TABLE_BASE) + 2 * NUM_PINS;
    localparam logic [31:0] VERSION_WORD =
        {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

    logic [7:0]                sel_q;
    logic [7:0]                offs;
    logic                      in_tbl;
    logic                      wr_win;
    logic [NUM_PINS-1:0][15:0] dest_shadow;

    assign offs   = sel_q - SEL_TABLE_BASE;
    assign in_tbl = (int'(sel_q) >= int'(SEL_TABLE_BASE)) && (int'(sel_q) < TBL_END);
    assign wr_win = bus_wr && (bus_addr == BUS_WIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 8'h00;
        end else if (bus_wr && (bus_addr == BUS_SEL)) begin
            sel_q <= bus_wdata[7:0];
        end
    end

    // Entry storage: high word goes to a shadow, committed with the low word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                rte_lo[i]      <= RTE_LO_RESET;
                rte_dest[i]    <= 16'h0000;
                dest_shadow[i] <= 16'h0000;
            end
        end else if (wr_win && in_tbl) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                if (offs[7:1] == 7'(i)) begin
                    if (offs[0]) begin
                        dest_shadow[i] <= bus_wdata[31:16];
                    end else begin
                        rte_lo[i]   <= unpack_low(bus_wdata);
                        rte_dest[i] <= dest_shadow[i];
                    end
                end
            end
        end
    end

    always_comb begin
        bus_rdata = 32'h0;
        unique case (bus_addr)
            BUS_SEL: bus_rdata = {24'h0, sel_q};
            BUS_WIN: begin
                if (sel_q == SEL_VERSION) begin
                    bus_rdata = VERSION_WORD;
                end else if (in_tbl) begin
                    for (int i = 0; i < NUM_PINS; i++) begin
                        if (offs[7:1] == 7'(i)) begin
                            bus_rdata = offs[0] ? {dest_shadow[i], 16'h0000}
                                                : pack_low(rte_lo[i]);
                        end
                    end
                end
            end
            default: bus_rdata = 32'h0;
        endcase
    end

    assign eoi_valid = bus_wr && (bus_addr == BUS_EOI);
    assign eoi_vec   = bus_wdata[7:0];

endmodule

// File: rtl/ioredir_pin.sv
module ioredir_pin
    import ioredir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  rte_lo_t    cfg,
    input  logic       grant,
    input  logic       eoi_valid,
    input  logic [7:0] eoi_vec,
    output logic       req
);

    logic [1:0] sync_q;
    logic       act;
    logic       act_d;
    logic       pend;
    logic       armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b00;
            act_d  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pin_in};
            act_d  <= act;
        end
    end

    // Polarity applied before detection
    assign act = sync_q[1] ^ cfg.pol;

    // Edge pending: masked edges are discarded outright
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (cfg.mask || cfg.trig) begin
            pend <= 1'b0;
        end else if (act && !act_d) begin
            pend <= 1'b1;
        end else if (grant) begin
            pend <= 1'b0;
        end
    end

    // Level arming: cleared when served, restored by a matching end-of-interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b1;
        end else if (grant && cfg.trig) begin
            armed <= 1'b0;
        end else if (eoi_valid && (eoi_vec == cfg.vec)) begin
            armed <= 1'b1;
        end
    end

    assign req = !cfg.mask && (cfg.trig ? (act && armed) : pend);

endmodule

// File: rtl/ioredir_arb.sv
module ioredir_arb
    import ioredir_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       req,
    input  rte_lo_t [NUM_PINS-1:0]    rte_lo,
    input  logic [NUM_PINS-1:0][15:0] rte_dest,
    input  logic                      msg_ready,
    output logic [NUM_PINS-1:0]       grant,
    output logic                      msg_valid,
    output logic [7:0]                msg_vec,
    output logic [15:0]               msg_dest,
    output logic [2:0]                msg_mode
);

    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    arb_state_e        state_q;
    arb_state_e        state_d;
    logic [IDX_W-1:0]  win_idx;
    logic              any_req;
    logic [7:0]        vec_q;
    logic [15:0]       dest_q;
    logic [2:0]        mode_q;

    assign any_req = |req;

    // Lowest index wins
    always_comb begin
        win_idx = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (req[i]) win_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: if (any_req)   state_d = ARB_SEND;
            ARB_SEND: if (msg_ready) state_d = ARB_IDLE;
            default:                 state_d = ARB_IDLE;
        endcase
    end

    always_comb begin
        grant = '0;
        if (state_q == ARB_IDLE && any_req) grant[win_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q  <= 8'h00;
            dest_q <= 16'h0000;
            mode_q <= DM_FIXED;
        end else if (state_q == ARB_IDLE && any_req) begin
            vec_q  <= rte_lo[win_idx].vec;
            dest_q <= rte_dest[win_idx];
            mode_q <= rte_lo[win_idx].mode;
        end
    end

    always_comb begin
        msg_valid = (state_q == ARB_SEND);
        msg_vec   = vec_q;
        msg_dest  = dest_q;
        msg_mode  = mode_q;
    end

endmodule

// File: rtl/ioredir_ctrl.sv
module ioredir_ctrl
    import ioredir_pkg::*;
#(
    parameter int         NUM_PINS = 4,
    parameter logic [7:0] VERSION  = 8'h21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic                bus_wr,
    input  logic [1:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vec,
    output logic [15:0]         msg_dest,
    output logic [2:0]          msg_mode
);

    rte_lo_t [NUM_PINS-1:0]    rte_lo;
    logic [NUM_PINS-1:0][15:0] rte_dest;
    logic                      eoi_valid;
    logic [7:0]                eoi_vec;
    logic [NUM_PINS-1:0]       pin_req;
    logic [NUM_PINS-1:0]       grant;
    logic [NUM_PINS-1:0]       pin_mask;
    logic [NUM_PINS-1:0]       pin_level;

    ioredir_table #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rte_lo    (rte_lo),
        .rte_dest  (rte_dest),
        .eoi_valid (eoi_valid),
        .eoi_vec   (eoi_vec)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        ioredir_pin u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_in    (irq_in[i]),
            .cfg       (rte_lo[i]),
            .grant     (grant[i]),
            .eoi_valid (eoi_valid),
            .eoi_vec   (eoi_vec),
            .req       (pin_req[i])
        );
        assign pin_mask[i]  = rte_lo[i].mask;
        assign pin_level[i] = rte_lo[i].trig;
    end

    ioredir_arb #(.NUM_PINS(NUM_PINS)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (pin_req),
        .rte_lo    (rte_lo),
        .rte_dest  (rte_dest),
        .msg_ready (msg_ready),
        .grant     (grant),
        .msg_valid (msg_valid),
        .msg_vec   (msg_vec),
        .msg_dest  (msg_dest),
        .msg_mode  (msg_mode)
    );

endmodule

// File: rtl/ioredir_chk.sv
module ioredir_chk #(
    parameter int NUM_PINS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] grant,
    input logic [NUM_PINS-1:0] pin_req,
    input logic [NUM_PINS-1:0] pin_mask,
    input logic [NUM_PINS-1:0] pin_level,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [7:0]          msg_vec,
    input logic [15:0]         msg_dest,
    input logic [2:0]          msg_mode
);

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vec)
                                    && $stable(msg_dest) && $stable(msg_mode)); // R10

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R9

    AST_GRANT_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> msg_valid); // R4

    AST_NO_GRANT_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (grant == '0)); // R9

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
        AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> !pin_mask[i]); // R6

        AST_LEVEL_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] && pin_level[i] |=> !pin_req[i]); // R7
    end

endmodule

bind ioredir_ctrl ioredir_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .pin_req   (pin_req),
    .pin_mask  (pin_mask),
    .pin_level (pin_level),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_vec   (msg_vec),
    .msg_dest  (msg_dest),
    .msg_mode  (msg_mode)
);

// File: tb/ioredir_ctrl_tb.sv
module ioredir_ctrl_tb;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] irq_in;
    logic          bus_wr;
    logic [1:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic          msg_valid;
    logic          msg_ready;
    logic [7:0]    msg_vec;
    logic [15:0]   msg_dest;
    logic [2:0]    msg_mode;

    int total = 0;
    int bad   = 0;
    int mcnt  = 0;
    logic [7:0]  mvec  [0:63];
    logic [15:0] mdest [0:63];
    logic [2:0]  mmode [0:63];

    always #10 clk = ~clk;

    ioredir_ctrl #(.NUM_PINS(NP), .VERSION(8'h21)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vec(msg_vec),
        .msg_dest(msg_dest), .msg_mode(msg_mode)
    );

    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            if (mcnt < 64) begin
                mvec[mcnt]  = msg_vec;
                mdest[mcnt] = msg_dest;
                mmode[mcnt] = msg_mode;
            end
            mcnt++;
        end
    end

    function automatic logic [7:0] vec_of(int n);
        return 8'(8'h40 + n);
    endfunction
    function automatic logic [15:0] dest_of(int n);
        return {8'(n + 1), 8'(n * 16 + 3)};
    endfunction
    function automatic logic [2:0] mode_of(int n);
        case (n % 4)
            0:       return 3'b000;
            1:       return 3'b001;
            2:       return 3'b010;
            default: return 3'b101;
        endcase
    endfunction
    function automatic logic [31:0] mklow(logic [7:0] v, logic [2:0] m,
                                          logic p, logic t, logic k);
        return {15'b0, k, t, 1'b0, p, 2'b00, m, v};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic bus_write(logic [1:0] a, logic [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic win_write(logic [7:0] s, logic [31:0] d);
        bus_write(2'd0, {24'h0, s});
        bus_write(2'd1, d);
    endtask

    task automatic win_read(logic [7:0] s, output logic [31:0] d);
        bus_write(2'd0, {24'h0, s});
        bus_addr = 2'd1;
        @(negedge clk);
        d = bus_rdata;
        #2;
    endtask

    task automatic pulse(int n);
        irq_in[n] = 1'b1;
        tick(3);
        irq_in[n] = 1'b0;
        tick(12);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] w;
        int base;
        rst_n = 1'b0; irq_in = '0; bus_wr = 1'b0; bus_addr = 2'd0;
        bus_wdata = 32'h0; msg_ready = 1'b1;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        chk("R2 valid after reset", 32'(msg_valid), 32'h0);
        win_read(8'h01, rd);
        chk("R1 version word", rd, {8'h00, 8'(NP - 1), 8'h00, 8'h21});
        for (int n = 0; n < NP; n++) begin
            win_read(8'(8'h10 + 2 * n), rd);
            chk("R2 masked at reset", rd, 32'h0001_0000);
        end

        // R3: program all entries, with junk in undefined bits
        for (int n = 0; n < NP; n++) begin
            win_write(8'(8'h11 + 2 * n), {dest_of(n), 16'hFFFF});
            win_read(8'(8'h11 + 2 * n), rd);
            chk("R3 high word readback", rd, {dest_of(n), 16'h0000});
            w = mklow(vec_of(n), mode_of(n), 1'b0, 1'b0, 1'b0) | 32'hFFFE_5800;
            win_write(8'(8'h10 + 2 * n), w);
            win_read(8'(8'h10 + 2 * n), rd);
            chk("R3 low word readback", rd, w & 32'h0001_A7FF);
        end

        // R4 / R11: one message per edge, fields per entry
        for (int n = 0; n < NP; n++) begin
            base = mcnt;
            pulse(n);
            chk("R4 one message per edge", 32'(mcnt), 32'(base + 1));
            chk("R4 vector", 32'(mvec[base]), 32'(vec_of(n)));
            chk("R4 destination", 32'(mdest[base]), 32'(dest_of(n)));
            chk("R11 delivery mode", 32'(mmode[base]), 32'(mode_of(n)));
        end
        base = mcnt;
        tick(20);
        chk("R4 no spurious message", 32'(mcnt), 32'(base));

        // R5: active low on pin 0
        win_write(8'h10, mklow(vec_of(0), mode_of(0), 1'b1, 1'b0, 1'b1));
        tick(5);
        irq_in[0] = 1'b1;
        tick(5);
        win_write(8'h10, mklow(vec_of(0), mode_of(0), 1'b1, 1'b0, 1'b0));
        tick(12);
        chk("R5 inactive level silent", 32'(mcnt), 32'(base));
        irq_in[0] = 1'b0;
        tick(12);
        chk("R5 falling input fires", 32'(mcnt), 32'(base + 1));
        chk("R5 vector", 32'(mvec[base]), 32'(vec_of(0)));
        win_write(8'h10, mklow(vec_of(0), mode_of(0), 1'b0, 1'b0, 1'b0));
        tick(12);

        // R6: masked edge dropped
        base = mcnt;
        win_write(8'h12, mklow(vec_of(1), mode_of(1), 1'b0, 1'b0, 1'b1));
        pulse(1);
        win_write(8'h12, mklow(vec_of(1), mode_of(1), 1'b0, 1'b0, 1'b0));
        tick(15);
        chk("R6 masked edge dropped", 32'(mcnt), 32'(base));

        // R9 / R10: simultaneous requests, receiver stalled
        msg_ready = 1'b0;
        irq_in[0] = 1'b1; irq_in[1] = 1'b1;
        for (int k = 0; k < 20 && !msg_valid; k++) tick(1);
        chk("R9 lowest index first", 32'(msg_vec), 32'(vec_of(0)));
        begin
            logic held;
            held = 1'b1;
            for (int k = 0; k < 5; k++) begin
                tick(1);
                if (!msg_valid || msg_vec != vec_of(0) || msg_dest != dest_of(0))
                    held = 1'b0;
            end
            chk("R10 held while stalled", 32'(held), 32'h1);
        end
        base = mcnt;
        msg_ready = 1'b1;
        irq_in[0] = 1'b0; irq_in[1] = 1'b0;
        tick(12);
        chk("R9 two messages", 32'(mcnt), 32'(base + 2));
        chk("R9 second is pin 1", 32'(mvec[base + 1]), 32'(vec_of(1)));

        // R8: destination shadow
        base = mcnt;
        win_write(8'h11, 32'hABCD_0000);
        pulse(0);
        chk("R8 old destination kept", 32'(mdest[base]), 32'(dest_of(0)));
        win_write(8'h10, mklow(vec_of(0), mode_of(0), 1'b0, 1'b0, 1'b0));
        pulse(0);
        chk("R8 destination committed", 32'(mdest[base + 1]), 32'hABCD);

        // R7: level pins 2 and 3 share vector 0x77
        win_write(8'h14, mklow(8'h77, 3'b000, 1'b0, 1'b1, 1'b0));
        win_write(8'h16, mklow(8'h77, 3'b000, 1'b0, 1'b1, 1'b0));
        base = mcnt;
        irq_in[2] = 1'b1; irq_in[3] = 1'b1;
        tick(20);
        chk("R7 one message each", 32'(mcnt), 32'(base + 2));
        chk("R9 level order pin 2", 32'(mdest[base]), 32'(dest_of(2)));
        chk("R9 level order pin 3", 32'(mdest[base + 1]), 32'(dest_of(3)));
        tick(20);
        chk("R7 silent while active", 32'(mcnt), 32'(base + 2));
        bus_write(2'd2, 32'h0000_0055);
        tick(20);
        chk("R7 other vector ignored", 32'(mcnt), 32'(base + 2));
        bus_write(2'd2, 32'h0000_0077);
        tick(20);
        chk("R7 shared re-arm", 32'(mcnt), 32'(base + 4));
        chk("R7 vector", 32'(mvec[base + 3]), 32'h77);
        irq_in[2] = 1'b0; irq_in[3] = 1'b0;
        tick(5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule